// File: doc/BRIEF.md
# MDIO Management Access Controller

This block carries out single Clause 22 management transactions between a host and an external Ethernet PHY over a two-wire serial management bus. The host first puts any write payload into a 16-bit data register. It then writes a 32-bit command register. This word holds the target PHY address, the target register number, a two-bit operation code, a divider select and a go bit. When the go bit is accepted, the controller builds the 64-bit management frame and shifts it out on MDIO. It also generates the management clock MDC from the system clock.

For a read, the controller releases MDIO at the turnaround. It then samples the 16 bits the PHY returns and places them in the data register when the frame ends. The go bit doubles as the busy flag. It reads 1 for the whole transaction and drops back to 0 in the cycle the transaction finishes, so software can poll it. Operation codes other than write and read never start bus activity. Command and data writes that arrive during a transaction are dropped.

Top module: `mdio_mgmt`

## Requirements
- R1: After a synchronous active-low reset, the command register and the data register read 0, MDC is low and the MDIO output enable is low.
- R2: A command write (wr_sel = 1) with the go bit (bit 0) at 1 and an operation code (bits 3:2) of 01 or 11 starts a transaction. Bit 0 of the command register then reads 1 from the next cycle and returns to 0 in the cycle the last MDC high phase ends. The busy time is 128 × H cycles, where H is the half period selected under R4.
- R3: The frame is sent as follows: 32 ones, then 0 and 1, then the opcode (0,1 for a write and 1,0 for a read), then the PHY address (command bits 25:21) and the register number (command bits 20:16), each MSB first.
- R4: The divider select in command bits 9:8 sets the MDC half period H in system clocks: 0 gives 4, 1 gives 8, 2 gives 16, 3 gives 62 (divide by 124). Each bit starts with an MDC low half and ends with a high half. MDC stays low while the controller is idle.
- R5: On a write, the turnaround is driven as 1 then 0. It is followed by the data register value, MSB first. MDIO changes value only at an MDC falling edge.
- R6: On a read, the output enable goes low at the start of the turnaround and stays low until the frame ends. MDIO is sampled at each MDC rising edge of the 16 data bits. The 16 captured bits (first one as MSB) are loaded into the data register when the transaction completes.
- R7: A command write with the go bit at 1 and an operation code of 00 or 10 is stored with bit 0 cleared. It produces no MDC edge and no MDIO drive.
- R8: While bit 0 of the command register is 1, writes to the command register and to the data register are ignored.
- R9: An accepted command write stores bits 31:1 as written, including the divider select. The controller afterwards changes only bit 0.
- R10: A write transaction leaves the data register holding the value that was written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | 1 selects the command register, 0 selects the data register |
| wr_data | input | 32 | Write value; the data register takes bits 15:0 |
| rd_cmd | output | 32 | Current command register contents, with the busy flag in bit 0 |
| rd_data | output | 16 | Current data register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven while mdio_oe is high |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the bus |

## Verification
Some properties are checked on every cycle by the assertions:
- MDC and the output enable stay quiet whenever the busy flag is low.
- The busy flag rises only after a command write with the go bit set.
- A bad operation code leaves the bus silent.
- A command write during a transaction leaves bits 31:1 untouched.
- MDIO never changes except at an MDC falling edge.
- Once a read has released the line, it stays released.

Other properties depend on the content of the frame, and only the bench scenarios can show them:
- the exact bit order of addresses and payload;
- the length of each divider setting;
- the value captured from the PHY;
- that a dropped data write leaves the register unchanged.

The bench's cycle model predicts all of these.

// File: rtl/mdio_mgmt_pkg.sv
// Shared constants and types for the management access controller.
// Assumes a Clause 22 frame of fixed 64-bit length.
package mdio_mgmt_pkg;
    localparam int CMD_W     = 32;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;
    localparam int PRE_BITS  = 32;
    localparam int FRAME_W   = 64;
    localparam int IDX_W     = $clog2(FRAME_W);
    localparam int TA_IDX    = 46;
    localparam int DATA_IDX  = 48;
    localparam int GO_BIT    = 0;
    localparam int OP_LO     = 2;
    localparam int SEL_LO    = 8;
    localparam int REG_LO    = 16;
    localparam int PHY_LO    = 21;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_BAD   = 2'b10,
        OP_READ  = 2'b11
    } mdio_op_e;

    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;
endpackage

// File: rtl/mdio_mgmt_clkdiv.sv
// Half-period tick generator for MDC.
// While run is high, it counts system clocks and pulses tick on the last
// cycle of each MDC half period. The length comes from a four-entry table
// indexed by the divider select. Assumes every HALFn >= 1.
module mdio_mgmt_clkdiv #(
    parameter int HALF0 = 4,
    parameter int HALF1 = 8,
    parameter int HALF2 = 16,
    parameter int HALF3 = 62
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] range_sel,
    output logic       tick
);
    localparam int MAX01 = (HALF0 > HALF1) ? HALF0 : HALF1;
    localparam int MAX23 = (HALF2 > HALF3) ? HALF2 : HALF3;
    localparam int MAXH  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CNT_W = $clog2(MAXH + 1);
    localparam int HALVES [4] = '{HALF0, HALF1, HALF2, HALF3};

    logic [CNT_W-1:0] half_tab [4];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    for (genvar g = 0; g < 4; g++) begin : g_tab
        assign half_tab[g] = CNT_W'(HALVES[g]);
    end

    // Last count of the selected half period.
    assign limit = half_tab[range_sel] - CNT_W'(1);
    assign tick  = run && (cnt_q == limit);

    // Half-period counter, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mdio_mgmt_seq.sv
// Frame sequencer: shifts the 64-bit management frame out on MDIO and
// toggles MDC on each divider tick. A bit starts with the MDC low half.
// MDIO moves only when MDC falls, and read data is sampled when MDC rises.
// Assumes start arrives only while idle.
module mdio_mgmt_seq
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              tick,
    input  logic              mdio_i,
    output logic              run,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    logic [FRAME_W-1:0] shreg_q;
    logic [IDX_W-1:0]   idx_q;
    logic               rd_q;
    logic [DATA_W-1:0]  cap_q;
    logic [FRAME_W-1:0] frame;
    logic               last_bit;
    logic [IDX_W:0]     next_idx;

    // Assemble the frame from the request.
    assign frame = {{PRE_BITS{1'b1}}, 2'b01,
                    (req.is_read ? 2'b10 : 2'b01),
                    req.phy, req.regn,
                    (req.is_read ? 2'b11 : 2'b10),
                    req.wdata};

    assign last_bit = (idx_q == IDX_W'(FRAME_W - 1));
    assign next_idx = {1'b0, idx_q} + (IDX_W+1)'(1);
    assign done     = run && mdc && tick && last_bit;
    assign mdio_o   = shreg_q[FRAME_W-1];
    assign rdata    = cap_q;

    // Bit sequencing, MDC phase, drive enable and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            mdc     <= 1'b0;
            mdio_oe <= 1'b0;
            shreg_q <= '0;
            idx_q   <= '0;
            rd_q    <= 1'b0;
            cap_q   <= '0;
        end else if (start) begin
            run     <= 1'b1;
            mdc     <= 1'b0;
            mdio_oe <= 1'b1;
            shreg_q <= frame;
            idx_q   <= '0;
            rd_q    <= req.is_read;
        end else if (run && tick) begin
            if (!mdc) begin
                mdc <= 1'b1;
                if (rd_q && (idx_q >= IDX_W'(DATA_IDX))) begin
                    cap_q <= {cap_q[DATA_W-2:0], mdio_i};
                end
            end else if (last_bit) begin
                run     <= 1'b0;
                mdc     <= 1'b0;
                mdio_oe <= 1'b0;
            end else begin
                mdc     <= 1'b0;
                idx_q   <= next_idx[IDX_W-1:0];
                shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                mdio_oe <= !(rd_q && (next_idx >= (IDX_W+1)'(TA_IDX)));
            end
        end
    end
endmodule

// File: rtl/mdio_mgmt_regs.sv
// Register file: command word (busy flag in bit 0) and data word.
// It accepts writes only while idle and decides whether a command write
// launches a transaction. It clears busy on done and loads read results.
module mdio_mgmt_regs
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CMD_W-1:0]  wr_data,
    input  logic              seq_done,
    input  logic [DATA_W-1:0] seq_rdata,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [DATA_W-1:0] data_q,
    output logic              start,
    output mdio_req_t         req,
    output logic [1:0]        range_sel
);
    mdio_op_e new_op;
    mdio_op_e cur_op;
    logic     busy;
    logic     cmd_wr;
    logic     data_wr;

    assign busy      = cmd_q[GO_BIT];
    assign new_op    = mdio_op_e'(wr_data[OP_LO+1:OP_LO]);
    assign cur_op    = mdio_op_e'(cmd_q[OP_LO+1:OP_LO]);
    assign cmd_wr    = wr_en && wr_sel && !busy;
    assign data_wr   = wr_en && !wr_sel && !busy;
    assign start     = cmd_wr && wr_data[GO_BIT] &&
                       ((new_op == OP_WRITE) || (new_op == OP_READ));
    assign range_sel = cmd_q[SEL_LO+1:SEL_LO];

    // Request handed to the sequencer together with start.
    always_comb begin
        req.is_read = (new_op == OP_READ);
        req.phy     = wr_data[PHY_LO+ADDR_W-1:PHY_LO];
        req.regn    = wr_data[REG_LO+ADDR_W-1:REG_LO];
        req.wdata   = data_q;
    end

    // Command word: store when idle, drop busy at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cmd_wr) begin
            cmd_q         <= wr_data;
            cmd_q[GO_BIT] <= start;
        end else if (seq_done) begin
            cmd_q[GO_BIT] <= 1'b0;
        end
    end

    // Data word: host load when idle, PHY result at the end of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (data_wr) begin
            data_q <= wr_data[DATA_W-1:0];
        end else if (seq_done && (cur_op == OP_READ)) begin
            data_q <= seq_rdata;
        end
    end
endmodule

// File: rtl/mdio_mgmt.sv
// Top of the management access controller: register file, MDC divider and
// frame sequencer. The host drives MDIO through mdio_o/mdio_oe and a pad
// outside this block; mdio_i is the bus value seen back.
module mdio_mgmt
    import mdio_mgmt_pkg::*;
#(
    parameter int HALF0 = 4,
    parameter int HALF1 = 8,
    parameter int HALF2 = 16,
    parameter int HALF3 = 62
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_cmd,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              start;
    logic              run;
    logic              tick;
    logic              done;
    logic [1:0]        range_sel;
    logic [DATA_W-1:0] seq_rdata;
    mdio_req_t         req;

    mdio_mgmt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .seq_done  (done),
        .seq_rdata (seq_rdata),
        .cmd_q     (rd_cmd),
        .data_q    (rd_data),
        .start     (start),
        .req       (req),
        .range_sel (range_sel)
    );

    mdio_mgmt_clkdiv #(
        .HALF0 (HALF0),
        .HALF1 (HALF1),
        .HALF2 (HALF2),
        .HALF3 (HALF3)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .range_sel (range_sel),
        .tick      (tick)
    );

    mdio_mgmt_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .req     (req),
        .tick    (tick),
        .mdio_i  (mdio_i),
        .run     (run),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (done),
        .rdata   (seq_rdata)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
// Protocol checker for mdio_mgmt, attached by bind. Observes ports only.
module mdio_mgmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [31:0] wr_data,
    input logic [31:0] rd_cmd,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R4: idle means MDC low and MDIO not driven.
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cmd[0] |-> (!mdc && !mdio_oe));

    // R2: busy rises only after a command write with the go bit.
    a_r2_busy_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_cmd[0]) |-> $past(wr_en && wr_sel && wr_data[0]));

    // R7: go bit with a non-Clause 22 opcode leaves the bus silent.
    a_r7_bad_op_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && !rd_cmd[0] && !wr_data[2]) |=>
        (!rd_cmd[0] && !mdc && !mdio_oe));

    // R8: command write during busy leaves bits 31:1 untouched.
    a_r8_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && rd_cmd[0]) |=> (rd_cmd[31:1] == $past(rd_cmd[31:1])));

    // R5: driven MDIO moves only on an MDC falling edge.
    a_r5_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |->
        (!mdc && $past(mdc)));

    // R6: a read that has released MDIO keeps it released.
    a_r6_stay_released: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd[0] && (rd_cmd[3:2] == 2'b11) && $past(rd_cmd[0]) && $past(!mdio_oe))
        |-> !mdio_oe);
endmodule

bind mdio_mgmt mdio_mgmt_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_cmd  (rd_cmd),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_mgmt_tb.sv
// Bench: behavioural cycle model of the controller and an attached PHY,
// compared with the outputs on every falling clock edge.
module mdio_mgmt_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_cmd;
    logic [15:0] rd_data;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    // reference model state
    bit          m_act;
    int          m_p;
    int          m_h;
    bit          m_read;
    logic [63:0] m_frame;
    logic [31:0] m_cmd;
    logic [15:0] m_data;
    logic [15:0] phy_val = 16'h0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt u_dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
        .wr_data (wr_data), .rd_cmd (rd_cmd), .rd_data (rd_data),
        .mdc (mdc), .mdio_o (mdio_o), .mdio_oe (mdio_oe), .mdio_i (mdio_i)
    );

    function automatic int half_of(input logic [1:0] s);
        case (s)
            2'd0: return 4;
            2'd1: return 8;
            2'd2: return 16;
            default: return 62;
        endcase
    endfunction

    function automatic logic [31:0] mk(input logic [4:0] pa, input logic [4:0] ra,
                                       input logic [1:0] op, input logic [1:0] sel,
                                       input logic go);
        return (32'(pa) << 21) | (32'(ra) << 16) | (32'(sel) << 8) |
               (32'(op) << 2) | 32'(go);
    endfunction

    // PHY model: returns phy_val MSB first during the data bits of a read.
    assign mdio_i = (m_act && m_read && ((m_p / (2*m_h)) >= 48)) ?
                    phy_val[63 - (m_p / (2*m_h))] : 1'b1;

    // Cycle model of the controller.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act <= 0; m_p <= 0; m_h <= 4; m_read <= 0;
            m_frame <= '0; m_cmd <= '0; m_data <= '0;
        end else if (m_act) begin
            if (m_p == 128*m_h - 1) begin
                m_act <= 0;
                m_cmd[0] <= 1'b0;
                if (m_read) m_data <= phy_val;
            end else begin
                m_p <= m_p + 1;
            end
        end else if (wr_en) begin
            if (wr_sel) begin
                m_cmd <= {wr_data[31:1], wr_data[0] & wr_data[2]};
                if (wr_data[0] && wr_data[2]) begin
                    m_act  <= 1;
                    m_p    <= 0;
                    m_h    <= half_of(wr_data[9:8]);
                    m_read <= wr_data[3];
                    m_frame <= {32'hFFFF_FFFF, 2'b01, (wr_data[3] ? 2'b10 : 2'b01),
                                wr_data[25:21], wr_data[20:16], 2'b10, m_data};
                end
            end else begin
                m_data <= wr_data[15:0];
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            int b;
            bit hi;
            b  = m_p / (2*m_h);
            hi = ((m_p / m_h) % 2) == 1;
            chk("R2", "busy", 32'(rd_cmd[0]), 32'(m_cmd[0]));
            chk("R9", "cmd", rd_cmd, m_cmd);
            chk("R6", "data", 32'(rd_data), 32'(m_data));
            chk("R4", "mdc", 32'(mdc), 32'(m_act && hi));
            chk("R6", "oe", 32'(mdio_oe), 32'(m_act && !(m_read && b >= 46)));
            if (m_act && mdio_oe)
                chk((b >= 46) ? "R5" : "R3", "mdio_o", 32'(mdio_o), 32'(m_frame[63-b]));
        end
    end

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic busy_len(input int exp_len, input string tag);
        int cnt = 0;
        while (rd_cmd[0]) begin
            cnt++;
            @(negedge clk);
        end
        chk(tag, "busy length", 32'(cnt), 32'(exp_len));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        // R1 reset state
        chk("R1", "cmd after reset", rd_cmd, 32'h0);
        chk("R1", "data after reset", 32'(rd_data), 32'h0);
        chk("R1", "mdc/oe after reset", {30'b0, mdc, mdio_oe}, 32'h0);

        // R5 R10: write, divide select 0
        wr(1'b0, 32'h0000_A5C3);
        wr(1'b1, mk(5'h11, 5'h0A, 2'b01, 2'd0, 1'b1));
        chk("R2", "busy after launch", 32'(rd_cmd[0]), 32'h1);
        busy_len(128*4, "R4");
        chk("R10", "data kept after write", 32'(rd_data), 32'h0000_A5C3);
        chk("R9", "cmd after write", rd_cmd, mk(5'h11, 5'h0A, 2'b01, 2'd0, 1'b0));

        // R6 R8: read, divide select 1, writes during busy
        phy_val = 16'h3C96;
        wr(1'b1, mk(5'h03, 5'h1C, 2'b11, 2'd1, 1'b1));
        repeat (100) @(negedge clk);
        wr(1'b1, mk(5'h1F, 5'h01, 2'b01, 2'd3, 1'b1));
        wr(1'b0, 32'h0000_FFFF);
        chk("R8", "cmd held during busy", rd_cmd, mk(5'h03, 5'h1C, 2'b11, 2'd1, 1'b1));
        chk("R8", "data held during busy", 32'(rd_data), 32'h0000_A5C3);
        while (rd_cmd[0]) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R6", "read result", 32'(rd_data), 32'h0000_3C96);

        // R7: bad opcodes with go bit
        wr(1'b1, mk(5'h05, 5'h05, 2'b00, 2'd0, 1'b1));
        repeat (40) @(negedge clk);
        chk("R7", "op 00 silent", {29'b0, rd_cmd[0], mdc, mdio_oe}, 32'h0);
        wr(1'b1, mk(5'h06, 5'h07, 2'b10, 2'd2, 1'b1));
        repeat (40) @(negedge clk);
        chk("R7", "op 10 silent", {29'b0, rd_cmd[0], mdc, mdio_oe}, 32'h0);
        chk("R7", "op 10 stored", rd_cmd, mk(5'h06, 5'h07, 2'b10, 2'd2, 1'b0));

        // R9: store without go, then read at divide 124
        wr(1'b1, mk(5'h00, 5'h00, 2'b00, 2'd3, 1'b0));
        chk("R9", "select stored", rd_cmd, mk(5'h00, 5'h00, 2'b00, 2'd3, 1'b0));
        phy_val = 16'h8001;
        wr(1'b1, mk(5'h1F, 5'h1F, 2'b11, 2'd3, 1'b1));
        busy_len(128*62, "R4");
        chk("R6", "read at slow divide", 32'(rd_data), 32'h0000_8001);
        chk("R9", "select kept", 32'(rd_cmd[9:8]), 32'h3);

        // R3 R5: zero payload, divide select 2
        wr(1'b0, 32'h0000_0000);
        wr(1'b1, mk(5'h00, 5'h00, 2'b01, 2'd2, 1'b1));
        busy_len(128*16, "R4");
        chk("R10", "zero payload kept", 32'(rd_data), 32'h0);

        finished = 1'b1;
        cmp_on = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule